// File: doc/BRIEF.md
# Audio delay fault monitor

This block watches a serial audio input link and the controller of a delay buffer for faults. The link is a bit clock and an LR (frame) clock, both asynchronous to the system clock. Each detected fault lands in a sticky flag of an 8-bit status byte. Software reads that byte and clears single flags by writing 0 to them.

The block also owns the run/stop decision for the delay engine. It has three states:
- **Idle:** the engine is stopped.
- **Sync:** the engine is armed and waiting for clean input.
- **Run:** the engine is running.

A one-cycle enable pulse arms the engine. It then enters Run after a set number of consecutive clean frames. Timing and configuration faults always stop it. Bit-count, overflow and underflow faults either stop it or send it back to Sync, depending on an auto-restart setting.

Top module: `dly_fault_mon`

## Requirements
- R1: Status byte layout is fixed: bit 7 timing fault, bit 6 configuration fault, bit 5 bit-count fault, bit 4 overflow, bit 3 underflow. Bits 2..0 always read 0, and every bit is 0 after reset.
- R2: Every flag is sticky. A register write with `reg_we_i` high clears each flag whose `reg_wdata_i` bit is 0. A write bit of 1 leaves its flag unchanged.
- R3: In Run, an LR clock edge that does not coincide with a bit-clock falling edge sets the timing flag and stops the engine. An enable pulse re-arms the engine even while this flag is 1.
- R4: At each frame end while armed (Sync or Run), a high `cfg_mismatch_i` sets the configuration flag and stops the engine, whatever the auto-restart setting.
- R5: In Run with `ext_sync_i` = 1, the bit-count flag sets at a frame end when the bit-clock rising edges counted in that frame are fewer than `in_len_i` or fewer than `out_len_i`. With `ext_sync_i` = 0 the count is never a fault.
- R6: An enable pulse clears the bit-count flag once.
- R7: In Run, `ovf_i` sets the overflow flag and `udf_i` sets the underflow flag. After a bit-count, overflow or underflow fault, `auto_restart_i` = 0 stops the engine and `auto_restart_i` = 1 returns it to Sync.
- R8: `udf_i` is ignored while `refill_i` is high.
- R9: Frames are counted between LR rising edges, and the first LR rise after reset only opens a frame. In Sync, `run_o` rises after two consecutive frames that are each clean: correct phase and no short count.
- R10: When a hardware set and a software clear hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrclk_i | input | 1 | LR frame clock (asynchronous) |
| in_len_i | input | LEN_W | Configured input bit length |
| out_len_i | input | LEN_W | Configured output data length |
| ext_sync_i | input | 1 | External sync mode; enables the bit-count check |
| auto_restart_i | input | 1 | 1: resume after resync on soft faults |
| en_set_i | input | 1 | One-cycle pulse: enable bit written to 1 |
| cfg_mismatch_i | input | 1 | Settings do not match the input signals |
| ovf_i | input | 1 | Delay buffer overflow pulse |
| udf_i | input | 1 | Delay buffer underflow pulse |
| refill_i | input | 1 | Buffer refilling after a delay change |
| reg_we_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 5 | Write data for status bits 7..3 |
| status_o | output | 8 | Sticky status byte |
| run_o | output | 1 | Delay engine run (1) / stop (0) |

## Verification
The monitor is driven with a range of frame patterns:
- clean 16-bit frames;
- 12-bit frames, checked against the input length alone, the output length alone, and with the count check turned off;
- one frame whose LR edge falls inside a bit-clock high phase;
- frames carrying a configuration mismatch.

Frame patterns separate three things: count faults from phase faults, the two length comparisons from each other, and the stop fault classes from the restart ones.

Pulse patterns complete the picture. Overflow and underflow pulses come with auto-restart on and off, and with and without refill masking. A fault pulse that lands in the same cycle as a clear write shows whether set beats clear.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_RUN  = 2'd2
  } run_st_e;

  // flag vector index 0..4 maps to status bits 3..7
  localparam int unsigned N_FLAGS = 5;
  localparam int unsigned F_UDF = 0;
  localparam int unsigned F_OVF = 1;
  localparam int unsigned F_BCK = 2;
  localparam int unsigned F_CFG = 3;
  localparam int unsigned F_TMG = 4;
endpackage

// File: rtl/dfm_sync2.sv
module dfm_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dfm_frame_mon.sv
module dfm_frame_mon #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_s_i,
  input  logic             lr_s_i,
  input  logic [LEN_W-1:0] in_len_i,
  input  logic [LEN_W-1:0] out_len_i,
  input  logic             ext_sync_i,
  output logic             frame_end_o,
  output logic             bad_edge_o,
  output logic             short_o,
  output logic             frame_ok_o
);
  localparam int unsigned CNT_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             bclk_q, lr_q, valid_q, ph_bad_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bclk_rise, bclk_fall, lr_edge, lr_rise;

  assign bclk_rise = bclk_s_i & ~bclk_q;
  assign bclk_fall = ~bclk_s_i & bclk_q;
  assign lr_edge   = lr_s_i ^ lr_q;
  assign lr_rise   = lr_s_i & ~lr_q;

  // LR must change together with a bit-clock falling edge
  assign bad_edge_o  = lr_edge & ~bclk_fall;
  assign frame_end_o = lr_rise & valid_q;
  assign short_o     = ext_sync_i &
                       ((cnt_q < CNT_W'(in_len_i)) | (cnt_q < CNT_W'(out_len_i)));
  assign frame_ok_o  = ~ph_bad_q & ~bad_edge_o & ~short_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      lr_q     <= 1'b0;
      valid_q  <= 1'b0;
      ph_bad_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      bclk_q <= bclk_s_i;
      lr_q   <= lr_s_i;
      if (lr_rise) begin
        valid_q  <= 1'b1;
        ph_bad_q <= 1'b0;
        cnt_q    <= bclk_rise ? CNT_W'(1) : '0;
      end else begin
        ph_bad_q <= ph_bad_q | bad_edge_o;
        if (bclk_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfm_run_ctl.sv
module dfm_run_ctl
  import dfm_pkg::*;
#(
  parameter int unsigned GOOD_FRAMES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_set_i,
  input  logic               auto_restart_i,
  input  logic               frame_end_i,
  input  logic               frame_ok_i,
  input  logic               short_i,
  input  logic               bad_edge_i,
  input  logic               cfg_mismatch_i,
  input  logic               ovf_i,
  input  logic               udf_i,
  input  logic               refill_i,
  output logic [N_FLAGS-1:0] set_o,
  output logic               run_o
);
  localparam int unsigned GW = $clog2(GOOD_FRAMES + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_FRAMES - 1);

  run_st_e        st_q, st_d;
  logic [GW-1:0]  good_q, good_d;
  logic           running, armed, stop_ev, soft_ev;

  assign running = (st_q == ST_RUN);
  assign armed   = (st_q != ST_IDLE);

  always_comb begin
    set_o        = '0;
    set_o[F_TMG] = running & bad_edge_i;
    set_o[F_CFG] = armed & frame_end_i & cfg_mismatch_i;
    set_o[F_BCK] = running & frame_end_i & short_i;
    set_o[F_OVF] = running & ovf_i;
    set_o[F_UDF] = running & udf_i & ~refill_i;
  end

  assign stop_ev = set_o[F_TMG] | set_o[F_CFG];
  assign soft_ev = set_o[F_BCK] | set_o[F_OVF] | set_o[F_UDF];

  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    if (en_set_i) begin
      st_d   = ST_SYNC;
      good_d = '0;
    end else begin
      unique case (st_q)
        ST_SYNC: begin
          if (frame_end_i) begin
            if (cfg_mismatch_i) begin
              st_d   = ST_IDLE;
              good_d = '0;
            end else if (!frame_ok_i) begin
              good_d = '0;
            end else if (good_q == GOOD_LAST) begin
              st_d   = ST_RUN;
              good_d = '0;
            end else begin
              good_d = good_q + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (stop_ev) st_d = ST_IDLE;
          else if (soft_ev) st_d = auto_restart_i ? ST_SYNC : ST_IDLE;
          good_d = '0;
        end
        default: good_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      good_q <= '0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
    end
  end

  assign run_o = running;
endmodule

// File: rtl/dfm_status.sv
module dfm_status #(
  parameter int unsigned          N        = 5,
  parameter logic [N-1:0]         AUTO_CLR = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic         auto_clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic clr;
    if (AUTO_CLR[k]) begin : g_ac
      assign clr = (we_i & ~wdata_i[k]) | auto_clr_i;
    end else begin : g_sw
      assign clr = we_i & ~wdata_i[k];
    end
    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[k] <= 1'b0;
      else         flag_o[k] <= set_i[k] | (flag_o[k] & ~clr);
    end
  end
endmodule

// File: rtl/dly_fault_mon.sv
module dly_fault_mon
  import dfm_pkg::*;
#(
  parameter int unsigned LEN_W       = 6,
  parameter int unsigned GOOD_FRAMES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  input  logic [LEN_W-1:0] in_len_i,
  input  logic [LEN_W-1:0] out_len_i,
  input  logic             ext_sync_i,
  input  logic             auto_restart_i,
  input  logic             en_set_i,
  input  logic             cfg_mismatch_i,
  input  logic             ovf_i,
  input  logic             udf_i,
  input  logic             refill_i,
  input  logic             reg_we_i,
  input  logic [7:3]       reg_wdata_i,
  output logic [7:0]       status_o,
  output logic             run_o
);
  localparam logic [N_FLAGS-1:0] BCK_MASK = N_FLAGS'(1) << F_BCK;

  logic [1:0]         link_s;
  logic               frame_end, bad_edge, short_f, frame_ok;
  logic [N_FLAGS-1:0] set_vec, flags;

  dfm_sync2 #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lrclk_i, bclk_i}),
    .q_o   (link_s)
  );

  dfm_frame_mon #(.LEN_W(LEN_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_s_i   (link_s[0]),
    .lr_s_i     (link_s[1]),
    .in_len_i   (in_len_i),
    .out_len_i  (out_len_i),
    .ext_sync_i (ext_sync_i),
    .frame_end_o(frame_end),
    .bad_edge_o (bad_edge),
    .short_o    (short_f),
    .frame_ok_o (frame_ok)
  );

  dfm_run_ctl #(.GOOD_FRAMES(GOOD_FRAMES)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_set_i      (en_set_i),
    .auto_restart_i(auto_restart_i),
    .frame_end_i   (frame_end),
    .frame_ok_i    (frame_ok),
    .short_i       (short_f),
    .bad_edge_i    (bad_edge),
    .cfg_mismatch_i(cfg_mismatch_i),
    .ovf_i         (ovf_i),
    .udf_i         (udf_i),
    .refill_i      (refill_i),
    .set_o         (set_vec),
    .run_o         (run_o)
  );

  dfm_status #(.N(N_FLAGS), .AUTO_CLR(BCK_MASK)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .auto_clr_i(en_set_i),
    .flag_o    (flags)
  );

  assign status_o = {flags, 3'b000};
endmodule

// File: rtl/dly_fault_mon_chk.sv
module dly_fault_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_set_i,
  input logic       reg_we_i,
  input logic [7:3] reg_wdata_i,
  input logic [7:0] status_o,
  input logic       run_o
);
  p_low_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000) else $error("low status bits set");

  for (genvar k = 3; k < 8; k++) begin : g_sticky
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[k] && !(reg_we_i && !reg_wdata_i[k]) && !(k == 5 && en_set_i)
      |=> status_o[k]) else $error("flag %0d dropped", k);
  end

  p_tmg_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[7]) && !$past(en_set_i) |-> !run_o)
    else $error("timing fault without stop");

  p_cfg_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) && !$past(en_set_i) |-> !run_o)
    else $error("config fault without stop");

  p_ovf_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) && !$past(en_set_i) |-> !run_o)
    else $error("overflow without stop");

  p_enable_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> !run_o) else $error("run right after enable");
endmodule

bind dly_fault_mon dly_fault_mon_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_set_i   (en_set_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .status_o   (status_o),
  .run_o      (run_o)
);

// File: tb/test_dly_fault_mon.sv
`timescale 1ns/1ps
module test_dly_fault_mon;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bclk_i = 1'b1, lrclk_i = 1'b0;
  logic [5:0] in_len_i = 6'd16, out_len_i = 6'd16;
  logic       ext_sync_i = 1'b1, auto_restart_i = 1'b1, en_set_i = 1'b0;
  logic       cfg_mismatch_i = 1'b0, ovf_i = 1'b0, udf_i = 1'b0, refill_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:3] reg_wdata_i = 5'h1f;
  logic [7:0] status_o;
  logic       run_o;

  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  dly_fault_mon i_dly_fault_mon (.*);

  // reference model
  int  m_st, m_good, m_cnt;
  bit  m_valid, m_ph;
  bit  m_flag [8];
  bit  hb [1:3];
  bit  hl [1:3];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_good = 0; m_cnt = 0; m_valid = 0; m_ph = 0;
      foreach (m_flag[i]) m_flag[i] = 0;
      for (int i = 1; i <= 3; i++) begin hb[i] = 0; hl[i] = 0; end
    end else begin
      bit br, bf, le, lr, bad_e, fend, shrt, ok, run, armed;
      bit s [8];
      br = hb[2] && !hb[3]; bf = !hb[2] && hb[3];
      le = hl[2] != hl[3];  lr = hl[2] && !hl[3];
      bad_e = le && !bf;
      fend  = lr && m_valid;
      shrt  = ext_sync_i && (m_cnt < in_len_i || m_cnt < out_len_i);
      ok    = !m_ph && !bad_e && !shrt;
      run   = (m_st == 2); armed = (m_st != 0);
      foreach (s[i]) s[i] = 0;
      s[7] = run && bad_e;
      s[6] = armed && fend && cfg_mismatch_i;
      s[5] = run && fend && shrt;
      s[4] = run && ovf_i;
      s[3] = run && udf_i && !refill_i;
      for (int b = 3; b < 8; b++) begin
        bit clr;
        clr = (reg_we_i && !reg_wdata_i[b]) || (b == 5 && en_set_i);
        m_flag[b] = s[b] || (m_flag[b] && !clr);
      end
      if (en_set_i) begin m_st = 1; m_good = 0; end
      else if (m_st == 1 && fend) begin
        if (cfg_mismatch_i) begin m_st = 0; m_good = 0; end
        else if (!ok) m_good = 0;
        else if (m_good + 1 >= 2) begin m_st = 2; m_good = 0; end
        else m_good++;
      end else if (m_st == 2) begin
        if (s[7] || s[6]) m_st = 0;
        else if (s[5] || s[4] || s[3]) m_st = auto_restart_i ? 1 : 0;
      end
      if (lr) begin m_valid = 1; m_ph = 0; m_cnt = br ? 1 : 0; end
      else begin m_ph = m_ph || bad_e; if (br && m_cnt < 255) m_cnt++; end
      hb[3] = hb[2]; hb[2] = hb[1]; hb[1] = bclk_i;
      hl[3] = hl[2]; hl[2] = hl[1]; hl[1] = lrclk_i;
    end
  end

  function automatic string tag_of(int b);
    case (b)
      7: return "R3"; 6: return "R4"; 5: return "R5";
      4: return "R7"; 3: return "R8"; default: return "R1";
    endcase
  endfunction

  // cycle compare against model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int b = 0; b < 8; b++) begin
        total++;
        if (status_o[b] !== m_flag[b]) begin
          bad++;
          $display("FAIL %s status bit %0d act=%0b exp=%0b t=%0t", tag_of(b), b, status_o[b], m_flag[b], $time);
        end
      end
      total++;
      if (run_o !== (m_st == 2)) begin
        bad++;
        $display("FAIL R9 run act=%0b exp=%0b t=%0t", run_o, (m_st == 2), $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic frame(input int nb, input bit badph);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk_i); bclk_i = 1'b0;
      if (i == 0) lrclk_i = 1'b1;
      else if (i == nb / 2 && !badph) lrclk_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i); bclk_i = 1'b1;
      @(negedge clk_i);
      if (badph && i == nb / 2) lrclk_i = 1'b0;
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame(16, 1'b0);
    idle(6);
  endtask

  task automatic pulse_en();
    @(negedge clk_i); en_set_i = 1'b1;
    @(negedge clk_i); en_set_i = 1'b0;
  endtask

  task automatic pulse_ovf();
    @(negedge clk_i); ovf_i = 1'b1;
    @(negedge clk_i); ovf_i = 1'b0;
  endtask

  task automatic pulse_udf();
    @(negedge clk_i); udf_i = 1'b1;
    @(negedge clk_i); udf_i = 1'b0;
  endtask

  task automatic wr(input logic [7:3] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0; reg_wdata_i = 5'h1f;
  endtask

  initial begin
    idle(4);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 reset status", status_o, 0);
    chk("R1 reset run", run_o, 0);

    pulse_en();
    frame(16, 0); frame(16, 0); idle(6);
    chk("R9 one frame only", run_o, 0);
    frame(16, 0); idle(6);
    chk("R9 run after two frames", run_o, 1);

    pulse_ovf(); idle(1);
    chk("R7 ovf flag", status_o[4], 1);
    chk("R7 ovf stop", run_o, 0);
    frames(3);
    chk("R7 auto resume", run_o, 1);

    wr(5'b11111); idle(1);
    chk("R2 write one no effect", status_o[4], 1);
    wr(5'b11101); idle(1);
    chk("R2 write zero clears", status_o[4], 0);

    refill_i = 1'b1; pulse_udf(); idle(1);
    chk("R8 masked udf", status_o[3], 0);
    chk("R8 still run", run_o, 1);
    refill_i = 1'b0;

    auto_restart_i = 1'b0; pulse_udf(); idle(1);
    chk("R7 udf flag", status_o[3], 1);
    frames(3);
    chk("R7 no auto resume", run_o, 0);

    wr(5'b00000); auto_restart_i = 1'b1; pulse_en(); frames(3);
    chk("R9 re-enable run", run_o, 1);

    frame(12, 0); frame(16, 0); idle(6);
    chk("R5 short vs in len", status_o[5], 1);
    frames(3);
    chk("R7 resume after count fault", run_o, 1);
    pulse_en(); idle(1);
    chk("R6 enable clears count flag", status_o[5], 0);
    frames(3);

    in_len_i = 6'd8;
    frame(12, 0); frame(16, 0); idle(6);
    chk("R5 short vs out len", status_o[5], 1);
    wr(5'b11011); frames(3);
    ext_sync_i = 1'b0;
    frame(12, 0); frame(16, 0); idle(6);
    chk("R5 internal mode no fault", status_o[5], 0);
    chk("R5 internal mode run", run_o, 1);
    ext_sync_i = 1'b1; in_len_i = 6'd16;

    pulse_ovf(); frames(3);
    @(negedge clk_i); ovf_i = 1'b1; reg_we_i = 1'b1; reg_wdata_i = 5'b11101;
    @(negedge clk_i); ovf_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = 5'h1f;
    chk("R10 set beats clear", status_o[4], 1);
    frames(3);

    frame(16, 1); idle(6);
    chk("R3 timing flag", status_o[7], 1);
    chk("R3 timing stop", run_o, 0);
    frames(3);
    chk("R3 stays stopped", run_o, 0);
    pulse_en(); frames(3);
    chk("R3 enable restarts with flag set", run_o, 1);
    chk("R3 flag kept", status_o[7], 1);

    cfg_mismatch_i = 1'b1;
    frame(16, 0); idle(6);
    chk("R4 cfg flag", status_o[6], 1);
    chk("R4 cfg stop", run_o, 0);
    cfg_mismatch_i = 1'b0;
    frames(3);
    chk("R4 no restart", run_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule